// File: doc/BRIEF.md
# Dual-channel UART host register interface

This block is the parallel host-bus front end of a two-channel UART. A host drives an 8-bit data bus, a 3-bit register address, an active-low chip select, a channel-select line and active-low read and write strobes. The block steers each access to one of two identical channel register files, decodes the address within that channel, and either captures write data or returns read data. The serial datapaths, FIFOs and baud counters sit outside and connect through the register ports: received data, interrupt, line and modem status come in; transmit data, control registers, the 16-bit divisor and single-cycle transmit-write and receive-pop strobes go out.

Strobes are synchronized into the system clock domain. A register update, and any read side effect, happens once per strobe pulse on its trailing edge. Read data is driven combinationally from the bus pins, so it is valid for as long as the read strobe is held. The bidirectional bus is modelled as separate input, output and output-enable ports. Bit 7 of each channel's line control register banks its low three addresses.

Top module: `duart_host_if`

## Requirements
- R1: While rst_ni is low every stored register of both channels is zero, including the bank-select bit (line control bit 7), so the low bank is visible after reset.
- R2: While cs_ni is high no register changes and bus_d_oe_o stays low, whatever the read and write strobes do.
- R3: chsel_i = 1 selects channel 1 (port index 0). chsel_i = 0 selects channel 2 (port index 1). An access touches only the selected channel.
- R4: With bank bit 0: address 0 writes tx_data_o and pulses tx_wr_o, and reads rx_data_i. Address 1 reads and writes ier_o. Address 2 writes fcr_o and reads isr_i.
- R5: With bank bit 1: address 0 holds the divisor low byte and address 1 the high byte (divisor_o = {high, low}). Address 2 holds afr_o. A read of address 0 in this bank causes no rx_pop_o.
- R6: Addresses 3 to 7 behave the same in both banks. 3 is line control (lcr_o, read/write), 4 is modem control (mcr_o, read/write), 5 reads lsr_i, 6 reads msr_i, and 7 is a read/write scratch byte. Writes to 5 and 6 change nothing.
- R7: The bank bit used to decode an access is the one in the selected channel's own line control register.
- R8: bus_d_oe_o is high exactly while cs_ni and rd_ni are both low. bus_d_o then carries the addressed register.
- R9: Each write pulse causes exactly one register update on its trailing edge, and at most one single-cycle tx_wr_o pulse.
- R10: Each read pulse of address 0 with bank bit 0 causes exactly one single-cycle rx_pop_o pulse on the selected channel, on the read's trailing edge.
- R11: If the read and write strobes overlap, the write is dropped and the read proceeds normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low |
| chsel_i | input | 1 | Channel select: 1 = channel 1, 0 = channel 2 |
| addr_i | input | 3 | Register address |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| bus_d_i | input | DW | Data bus, host to block |
| bus_d_o | output | DW | Data bus, block to host |
| bus_d_oe_o | output | 1 | Bus drive enable |
| rx_data_i | input | 2xDW | Received byte per channel |
| isr_i | input | 2xDW | Interrupt status per channel |
| lsr_i | input | 2xDW | Line status per channel |
| msr_i | input | 2xDW | Modem status per channel |
| tx_data_o | output | 2xDW | Transmit byte per channel |
| tx_wr_o | output | 2 | Transmit write strobe per channel |
| rx_pop_o | output | 2 | Receive pop strobe per channel |
| ier_o | output | 2xDW | Interrupt enable per channel |
| fcr_o | output | 2xDW | FIFO control per channel |
| lcr_o | output | 2xDW | Line control per channel |
| mcr_o | output | 2xDW | Modem control per channel |
| afr_o | output | 2xDW | Alternate function per channel |
| divisor_o | output | 2x2DW | Baud divisor per channel |

## Verification
Each channel is written with different values, so that a mix-up in channel steering shows up as wrong data on the other channel. Every address is read in both banks with one channel banked and the other not, which separates per-channel bank decoding from a shared bit. Write pulses with chip select high, writes to the status addresses and overlapped read/write pulses each test a path that must leave the model's registers untouched. Strobe counts are compared on every clock so that double or missing pulses are seen.

// File: rtl/duart_if_pkg.sv
package duart_if_pkg;
  localparam int AW       = 3;
  localparam int NUM_CH   = 2;
  localparam int BANK_BIT = 7;

  typedef enum logic [AW-1:0] {
    RA_DATA = 3'd0,
    RA_IER  = 3'd1,
    RA_FCR  = 3'd2,
    RA_LCR  = 3'd3,
    RA_MCR  = 3'd4,
    RA_LSR  = 3'd5,
    RA_MSR  = 3'd6,
    RA_SCR  = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/duart_sync.sv
module duart_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] pipe_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < STAGES; k++) pipe_q[k] <= RST_VAL;
    end else begin
      pipe_q[0] <= d_i;
      for (int k = 1; k < STAGES; k++) pipe_q[k] <= pipe_q[k-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/duart_access_ctrl.sv
module duart_access_ctrl
  import duart_if_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  // raw pins, used only to capture address/data while the strobe is low
  input  logic          cs_ni,
  input  logic          rd_ni,
  input  logic          wr_ni,
  input  logic          chsel_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  // synchronized strobes
  input  logic          cs_s_i,
  input  logic          rd_s_i,
  input  logic          wr_s_i,
  output logic          wr_commit_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic          wr_ch_o,
  output logic          rd_done_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          rd_ch_o
);
  logic wr_lvl, rd_lvl;
  logic wr_seen_q, wr_bad_q, rd_seen_q;
  logic wr_end, rd_end;

  assign wr_lvl = ~cs_s_i & ~wr_s_i;
  assign rd_lvl = ~cs_s_i & ~rd_s_i;
  assign wr_end = wr_seen_q & ~wr_lvl;
  assign rd_end = rd_seen_q & ~rd_lvl;

  // channel index 0 is channel 1 (chsel high)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_addr_o <= '0;
      wr_data_o <= '0;
      wr_ch_o   <= 1'b0;
      rd_addr_o <= '0;
      rd_ch_o   <= 1'b0;
    end else begin
      if (!cs_ni && !wr_ni) begin
        wr_addr_o <= addr_i;
        wr_data_o <= data_i;
        wr_ch_o   <= ~chsel_i;
      end
      if (!cs_ni && !rd_ni) begin
        rd_addr_o <= addr_i;
        rd_ch_o   <= ~chsel_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_seen_q <= 1'b0;
      wr_bad_q  <= 1'b0;
      rd_seen_q <= 1'b0;
    end else begin
      if (wr_end) begin
        wr_seen_q <= 1'b0;
        wr_bad_q  <= 1'b0;
      end else begin
        if (wr_lvl) wr_seen_q <= 1'b1;
        // overlapping read poisons the pending write
        if (rd_lvl && (wr_lvl || wr_seen_q)) wr_bad_q <= 1'b1;
      end
      if (rd_end)      rd_seen_q <= 1'b0;
      else if (rd_lvl) rd_seen_q <= 1'b1;
    end
  end

  assign wr_commit_o = wr_end & ~wr_bad_q & ~rd_lvl;
  assign rd_done_o   = rd_end;
endmodule

// File: rtl/duart_chan_regs.sv
module duart_chan_regs
  import duart_if_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  input  logic [AW-1:0] paddr_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o,
  input  logic [DW-1:0] rx_data_i,
  input  logic [DW-1:0] isr_i,
  input  logic [DW-1:0] lsr_i,
  input  logic [DW-1:0] msr_i,
  output logic [DW-1:0] tx_data_o,
  output logic          tx_wr_o,
  output logic          rx_pop_o,
  output logic [DW-1:0] ier_o,
  output logic [DW-1:0] fcr_o,
  output logic [DW-1:0] lcr_o,
  output logic [DW-1:0] mcr_o,
  output logic [DW-1:0] afr_o,
  output logic [2*DW-1:0] divisor_o
);
  logic [DW-1:0] scr_q, dll_q, dlm_q;
  logic          bank;

  assign bank      = lcr_o[BANK_BIT];
  assign divisor_o = {dlm_q, dll_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_data_o <= '0;
      ier_o     <= '0;
      fcr_o     <= '0;
      lcr_o     <= '0;
      mcr_o     <= '0;
      afr_o     <= '0;
      scr_q     <= '0;
      dll_q     <= '0;
      dlm_q     <= '0;
      tx_wr_o   <= 1'b0;
      rx_pop_o  <= 1'b0;
    end else begin
      tx_wr_o  <= 1'b0;
      rx_pop_o <= pop_i && (reg_addr_e'(paddr_i) == RA_DATA) && !bank;
      if (we_i) begin
        unique case (reg_addr_e'(waddr_i))
          RA_DATA: if (bank) dll_q <= wdata_i;
                   else begin
                     tx_data_o <= wdata_i;
                     tx_wr_o   <= 1'b1;
                   end
          RA_IER:  if (bank) dlm_q <= wdata_i; else ier_o <= wdata_i;
          RA_FCR:  if (bank) afr_o <= wdata_i; else fcr_o <= wdata_i;
          RA_LCR:  lcr_o <= wdata_i;
          RA_MCR:  mcr_o <= wdata_i;
          RA_SCR:  scr_q <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (reg_addr_e'(raddr_i))
      RA_DATA: rdata_o = bank ? dll_q : rx_data_i;
      RA_IER:  rdata_o = bank ? dlm_q : ier_o;
      RA_FCR:  rdata_o = bank ? afr_o : isr_i;
      RA_LCR:  rdata_o = lcr_o;
      RA_MCR:  rdata_o = mcr_o;
      RA_LSR:  rdata_o = lsr_i;
      RA_MSR:  rdata_o = msr_i;
      default: rdata_o = scr_q;
    endcase
  end
endmodule

// File: rtl/duart_host_if.sv
module duart_host_if
  import duart_if_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        cs_ni,
  input  logic                        chsel_i,
  input  logic [AW-1:0]               addr_i,
  input  logic                        rd_ni,
  input  logic                        wr_ni,
  input  logic [DW-1:0]               bus_d_i,
  output logic [DW-1:0]               bus_d_o,
  output logic                        bus_d_oe_o,
  input  logic [NUM_CH-1:0][DW-1:0]   rx_data_i,
  input  logic [NUM_CH-1:0][DW-1:0]   isr_i,
  input  logic [NUM_CH-1:0][DW-1:0]   lsr_i,
  input  logic [NUM_CH-1:0][DW-1:0]   msr_i,
  output logic [NUM_CH-1:0][DW-1:0]   tx_data_o,
  output logic [NUM_CH-1:0]           tx_wr_o,
  output logic [NUM_CH-1:0]           rx_pop_o,
  output logic [NUM_CH-1:0][DW-1:0]   ier_o,
  output logic [NUM_CH-1:0][DW-1:0]   fcr_o,
  output logic [NUM_CH-1:0][DW-1:0]   lcr_o,
  output logic [NUM_CH-1:0][DW-1:0]   mcr_o,
  output logic [NUM_CH-1:0][DW-1:0]   afr_o,
  output logic [NUM_CH-1:0][2*DW-1:0] divisor_o
);
  logic          cs_s, rd_s, wr_s;
  logic          wr_commit, wr_ch, rd_done, rd_ch;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [DW-1:0] wr_data;
  logic [NUM_CH-1:0][DW-1:0] rdata;

  duart_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, rd_ni, wr_ni}),
    .q_o   ({cs_s, rd_s, wr_s})
  );

  duart_access_ctrl #(.DW(DW)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_ni      (cs_ni),
    .rd_ni      (rd_ni),
    .wr_ni      (wr_ni),
    .chsel_i    (chsel_i),
    .addr_i     (addr_i),
    .data_i     (bus_d_i),
    .cs_s_i     (cs_s),
    .rd_s_i     (rd_s),
    .wr_s_i     (wr_s),
    .wr_commit_o(wr_commit),
    .wr_addr_o  (wr_addr),
    .wr_data_o  (wr_data),
    .wr_ch_o    (wr_ch),
    .rd_done_o  (rd_done),
    .rd_addr_o  (rd_addr),
    .rd_ch_o    (rd_ch)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam logic IDX = 1'(i);
    duart_chan_regs #(.DW(DW)) u_regs (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .we_i     (wr_commit && (wr_ch == IDX)),
      .waddr_i  (wr_addr),
      .wdata_i  (wr_data),
      .pop_i    (rd_done && (rd_ch == IDX)),
      .paddr_i  (rd_addr),
      .raddr_i  (addr_i),
      .rdata_o  (rdata[i]),
      .rx_data_i(rx_data_i[i]),
      .isr_i    (isr_i[i]),
      .lsr_i    (lsr_i[i]),
      .msr_i    (msr_i[i]),
      .tx_data_o(tx_data_o[i]),
      .tx_wr_o  (tx_wr_o[i]),
      .rx_pop_o (rx_pop_o[i]),
      .ier_o    (ier_o[i]),
      .fcr_o    (fcr_o[i]),
      .lcr_o    (lcr_o[i]),
      .mcr_o    (mcr_o[i]),
      .afr_o    (afr_o[i]),
      .divisor_o(divisor_o[i])
    );
  end

  // read path is combinational from the pins
  assign bus_d_oe_o = ~cs_ni & ~rd_ni;
  assign bus_d_o    = rdata[~chsel_i];
endmodule

// File: rtl/duart_host_if_chk.sv
module duart_host_if_chk
  import duart_if_pkg::*;
#(
  parameter int DW = 8
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        cs_ni,
  input logic                        rd_ni,
  input logic                        bus_d_oe_o,
  input logic [NUM_CH-1:0]           tx_wr_o,
  input logic [NUM_CH-1:0]           rx_pop_o,
  input logic [NUM_CH-1:0][DW-1:0]   lcr_o,
  input logic [NUM_CH-1:0][DW-1:0]   mcr_o,
  input logic [NUM_CH-1:0][DW-1:0]   ier_o,
  input logic [NUM_CH-1:0][2*DW-1:0] divisor_o
);
  localparam int IDLE_LIM = 5;
  logic [2:0] idle_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 idle_cnt <= '0;
    else if (!cs_ni)             idle_cnt <= '0;
    else if (idle_cnt != 3'(IDLE_LIM)) idle_cnt <= idle_cnt + 3'd1;
  end

  a_r1_reset_clear: assert property (@(posedge clk_i)
    !rst_ni |-> (lcr_o == '0 && mcr_o == '0 && ier_o == '0 && divisor_o == '0));

  a_r2_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_cnt == 3'(IDLE_LIM)) |-> ($stable(lcr_o) && $stable(mcr_o) && $stable(ier_o)
                                    && $stable(divisor_o) && tx_wr_o == '0));

  a_r8_oe_only_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_d_oe_o |-> (!cs_ni && !rd_ni));

  a_r8_oe_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && !rd_ni) |-> bus_d_oe_o);

  a_r3_one_channel_tx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(tx_wr_o));

  a_r3_one_channel_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rx_pop_o));

  a_r9_tx_wr_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_wr_o != '0) |=> (tx_wr_o == '0));

  a_r10_pop_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_pop_o != '0) |=> (rx_pop_o == '0));
endmodule

bind duart_host_if duart_host_if_chk #(.DW(DW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_ni     (cs_ni),
  .rd_ni     (rd_ni),
  .bus_d_oe_o(bus_d_oe_o),
  .tx_wr_o   (tx_wr_o),
  .rx_pop_o  (rx_pop_o),
  .lcr_o     (lcr_o),
  .mcr_o     (mcr_o),
  .ier_o     (ier_o),
  .divisor_o (divisor_o)
);

// File: tb/duart_host_if_tb_top.sv
module duart_host_if_tb_top;
  localparam int DW = 8;

  logic clk_i = 1'b0;
  logic rst_ni;
  logic cs_ni = 1'b1, chsel_i = 1'b1, rd_ni = 1'b1, wr_ni = 1'b1;
  logic [2:0] addr_i = '0;
  logic [DW-1:0] bus_d_i = '0;
  logic [DW-1:0] bus_d_o;
  logic bus_d_oe_o;
  logic [1:0][DW-1:0] rx_data_i, isr_i, lsr_i, msr_i;
  logic [1:0][DW-1:0] tx_data_o, ier_o, fcr_o, lcr_o, mcr_o, afr_o;
  logic [1:0] tx_wr_o, rx_pop_o;
  logic [1:0][2*DW-1:0] divisor_o;

  always #4 clk_i = ~clk_i;

  assign rx_data_i = {8'hC3, 8'h5A};
  assign isr_i     = {8'h02, 8'h01};
  assign lsr_i     = {8'h61, 8'h60};
  assign msr_i     = {8'hB1, 8'hB0};

  duart_host_if #(.DW(DW), .SYNC_STAGES(2)) dut_i (.*);

  // reference model, index 0 = channel 1
  logic [7:0] m_ier[2], m_fcr[2], m_lcr[2], m_mcr[2], m_scr[2];
  logic [7:0] m_dll[2], m_dlm[2], m_afr[2], m_thr[2];
  int exp_tx[2], exp_pop[2], got_tx[2], got_pop[2];
  int n_run = 0, n_fail = 0;
  bit busy = 1'b1, done = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input int ix, input logic [2:0] a);
    logic bk = m_lcr[ix][7];
    case (a)
      3'd0: return bk ? m_dll[ix] : rx_data_i[ix];
      3'd1: return bk ? m_dlm[ix] : m_ier[ix];
      3'd2: return bk ? m_afr[ix] : isr_i[ix];
      3'd3: return m_lcr[ix];
      3'd4: return m_mcr[ix];
      3'd5: return lsr_i[ix];
      3'd6: return msr_i[ix];
      default: return m_scr[ix];
    endcase
  endfunction

  task automatic model_write(input int ix, input logic [2:0] a, input logic [7:0] d);
    logic bk = m_lcr[ix][7];
    case (a)
      3'd0: if (bk) m_dll[ix] = d; else begin m_thr[ix] = d; exp_tx[ix]++; end
      3'd1: if (bk) m_dlm[ix] = d; else m_ier[ix] = d;
      3'd2: if (bk) m_afr[ix] = d; else m_fcr[ix] = d;
      3'd3: m_lcr[ix] = d;
      3'd4: m_mcr[ix] = d;
      3'd7: m_scr[ix] = d;
      default: ;
    endcase
  endtask

  always @(negedge clk_i) begin
    for (int i = 0; i < 2; i++) begin
      got_tx[i]  += int'(tx_wr_o[i]);
      got_pop[i] += int'(rx_pop_o[i]);
    end
    if (!busy && rst_ni && !done) begin
      for (int i = 0; i < 2; i++) begin
        check("R9 lcr state", lcr_o[i], m_lcr[i]);
        check("R9 mcr state", mcr_o[i], m_mcr[i]);
        check("R4 ier state", ier_o[i], m_ier[i]);
        check("R4 fcr state", fcr_o[i], m_fcr[i]);
        check("R4 tx data", tx_data_o[i], m_thr[i]);
        check("R5 afr state", afr_o[i], m_afr[i]);
        check("R5 divisor", divisor_o[i], {m_dlm[i], m_dll[i]});
        check("R9 tx_wr count", got_tx[i], exp_tx[i]);
        check("R10 pop count", got_pop[i], exp_pop[i]);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic do_write(input int ch, input logic [2:0] a, input logic [7:0] d);
    busy = 1'b1;
    chsel_i = (ch == 1); addr_i = a; bus_d_i = d; cs_ni = 1'b0; wr_ni = 1'b0;
    idle(3);
    wr_ni = 1'b1;
    idle(1);
    cs_ni = 1'b1; bus_d_i = 8'hFF; addr_i = 3'd0;
    idle(6);
    model_write(ch - 1, a, d);
    busy = 1'b0;
  endtask

  task automatic do_read(input int ch, input logic [2:0] a, input string req);
    int ix = ch - 1;
    busy = 1'b1;
    chsel_i = (ch == 1); addr_i = a; cs_ni = 1'b0; rd_ni = 1'b0;
    idle(2);
    check({req, " oe"}, bus_d_oe_o, 1'b1);
    check({req, " data"}, bus_d_o, exp_read(ix, a));
    rd_ni = 1'b1;
    idle(1);
    cs_ni = 1'b1;
    idle(6);
    if (a == 3'd0 && !m_lcr[ix][7]) exp_pop[ix]++;
    busy = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 2; i++) begin
      m_ier[i] = 0; m_fcr[i] = 0; m_lcr[i] = 0; m_mcr[i] = 0; m_scr[i] = 0;
      m_dll[i] = 0; m_dlm[i] = 0; m_afr[i] = 0; m_thr[i] = 0;
      exp_tx[i] = 0; exp_pop[i] = 0; got_tx[i] = 0; got_pop[i] = 0;
    end
    rst_ni = 1'b1;
    #1 rst_ni = 1'b0;
    idle(3);
    check("R1 lcr reset", {lcr_o[1], lcr_o[0]}, 16'h0);
    check("R1 divisor reset", {divisor_o[1], divisor_o[0]}, 32'h0);
    check("R8 oe idle", bus_d_oe_o, 1'b0);
    rst_ni = 1'b1;
    idle(2);
    busy = 1'b0;

    do_read(1, 3'd1, "R1 ier after reset");
    do_read(2, 3'd2, "R1 low bank isr");

    // R2: read strobe with chip deselected
    rd_ni = 1'b0; idle(2);
    check("R2 oe with cs high", bus_d_oe_o, 1'b0);
    rd_ni = 1'b1; idle(2);

    // R3/R4/R6 distinct values per channel
    do_write(1, 3'd1, 8'h0F);
    do_write(1, 3'd2, 8'hC1);
    do_write(1, 3'd7, 8'h3C);
    do_write(1, 3'd4, 8'h13);
    do_write(2, 3'd1, 8'h05);
    do_write(2, 3'd7, 8'h99);
    do_read(1, 3'd1, "R3 ch1 ier");
    do_read(2, 3'd1, "R3 ch2 ier");
    do_read(1, 3'd7, "R6 ch1 scratch");
    do_read(2, 3'd7, "R6 ch2 scratch");
    do_read(1, 3'd4, "R6 mcr");
    do_read(1, 3'd2, "R4 isr read");

    do_write(1, 3'd0, 8'h41);
    do_read(2, 3'd0, "R10 rx read ch2");
    do_read(1, 3'd0, "R10 rx read ch1");

    // R5/R7 bank channel 1 only
    do_write(1, 3'd3, 8'h83);
    do_write(1, 3'd0, 8'h34);
    do_write(1, 3'd1, 8'h12);
    do_write(1, 3'd2, 8'h07);
    check("R5 divisor ch1", divisor_o[0], 16'h1234);
    do_read(1, 3'd0, "R5 dll no pop");
    do_read(1, 3'd1, "R5 dlm");
    do_read(1, 3'd2, "R5 afr");
    do_read(2, 3'd0, "R7 ch2 low bank rx");
    do_read(2, 3'd1, "R7 ch2 ier");
    do_write(2, 3'd0, 8'h77);
    for (int a = 3; a < 8; a++) begin
      do_read(1, 3'(a), "R6 high bank shared");
      do_read(2, 3'(a), "R6 low bank shared");
    end

    // R6 status addresses ignore writes
    do_write(1, 3'd5, 8'hEE);
    do_write(2, 3'd6, 8'hEE);
    do_read(1, 3'd5, "R6 lsr after write");
    do_read(2, 3'd6, "R6 msr after write");

    // R2 write pulse while deselected
    busy = 1'b1;
    chsel_i = 1'b1; addr_i = 3'd3; bus_d_i = 8'h00; wr_ni = 1'b0;
    idle(3); wr_ni = 1'b1; idle(6);
    busy = 1'b0;
    check("R2 lcr unchanged", lcr_o[0], 8'h83);
    do_read(1, 3'd3, "R2 lcr read");

    // R11 overlapped strobes
    busy = 1'b1;
    chsel_i = 1'b1; addr_i = 3'd7; bus_d_i = 8'hEE; cs_ni = 1'b0;
    rd_ni = 1'b0; wr_ni = 1'b0;
    idle(2);
    check("R11 read proceeds", bus_d_o, 8'h3C);
    idle(1);
    rd_ni = 1'b1; wr_ni = 1'b1;
    idle(1); cs_ni = 1'b1; idle(6);
    busy = 1'b0;
    do_read(1, 3'd7, "R11 scratch unchanged");
    busy = 1'b1;
    chsel_i = 1'b0; addr_i = 3'd0; bus_d_i = 8'h55; cs_ni = 1'b0;
    rd_ni = 1'b0; wr_ni = 1'b0;
    idle(3);
    rd_ni = 1'b1; wr_ni = 1'b1;
    idle(1); cs_ni = 1'b1; idle(6);
    exp_pop[1]++;
    busy = 1'b0;
    idle(2);
    check("R11 no tx write", tx_data_o[1], 8'h77);

    // leave bank on channel 1
    do_write(1, 3'd3, 8'h03);
    do_read(1, 3'd1, "R4 ier back in low bank");
    do_read(1, 3'd0, "R10 pop after bank clear");
    idle(4);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule